// File: doc/BRIEF.md
# Banked Indirect Configuration Port

This block is a small configuration register file that a host reaches through only two locations: an 8-bit pointer and a 16-bit data window. The pointer chooses one of two channel banks (primary or secondary) and one of seven register slots within the bank. It also holds three bus-behaviour flags that the block drives straight out. Reads and writes at the data window reach the slot the pointer names. When the pointer's auto-advance flag is set, the slot number steps forward after every data access, so a whole bank can be loaded or dumped in one run.

Each bank holds two 16-bit base addresses (command block and control block), a general configuration byte, a 10-bit read-ahead count with its enable and a FIFO-clear strobe, and two timing bytes. Every field resets to a defined value, and the two address bases reset to different values in each bank. Write-only registers and bits read back as zero. The decoded values leave the block on per-bank output vectors for the logic that uses them.

Top module: `ide_cfg_port`

## Requirements
- R1: After synchronous reset the pointer reads 0x0050. Bank 0 holds command base 0x1F0 and control base 0x3F6, and bank 1 holds 0x170 and 0x376. Both banks hold general byte 0x01, data timing 0xF5 and control timing 0xDE, with a zero read-ahead count and enable.
- R2: Pointer bit 3 selects the bank (0 primary, 1 secondary) and pointer bits 2..0 select the slot. A data write changes only that slot of that bank.
- R3: When pointer bit 7 is 1, the slot number advances by one after each data-window read or write. When bit 7 is 0 it holds.
- R4: Auto-advance from slot 6, or from slot 7, continues at slot 0.
- R5: Slot 7 holds nothing: writes to it change no output, and reads of it return 0.
- R6: Slot 2 is written with bits 7..0 of the read-ahead count. Slot 3 is written with count bits 9..8 in its bits 1..0 and the read-ahead enable in its bit 7. Both slots read as 0.
- R7: A write to slot 3 with bit 6 set raises that bank's FIFO-clear output for exactly the one cycle after the write. The bit is not stored.
- R8: Slots 1, 5 and 6 store only the low byte, and they read with a zero upper byte. Bit 2 of slot 1 is write-only: it reads as 0 but still appears on the general-configuration output.
- R9: Pointer bit 6 drives the posted-write wait output, bit 5 drives the burst-disable output and bit 4 drives the medium-select-timing output. Bit 5 reads back as 0, and a pointer read has a zero upper byte.
- R10: Each bank's drive-reset output follows bit 6 of that bank's general configuration byte.
- R11: A cycle with both write and read strobes at the data window is one write access, and it advances the slot at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_data | input | 1 | 1 addresses the data window, 0 the pointer |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data (pointer uses bits 7..0) |
| rdata | output | 16 | Read data for the addressed location, combinational |
| post_wait_o | output | 1 | Pointer bit 6 |
| burst_dis_o | output | 1 | Pointer bit 5 |
| devsel_med_o | output | 1 | Pointer bit 4 |
| cmd_base_o | output | 32 | Command block base, bank b at [16b+15:16b] |
| ctl_base_o | output | 32 | Control block base per bank |
| gen_cfg_o | output | 16 | General configuration byte per bank |
| ide_rst_o | output | 2 | Drive reset per bank |
| ra_count_o | output | 20 | Read-ahead count, 10 bits per bank |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO clear per bank |
| data_tim_o | output | 16 | Data port timing byte per bank |
| ctrl_tim_o | output | 16 | Command/control timing byte per bank |

## Verification
The properties take for granted that the strobes and `sel_data` are known and stable across each rising edge, and that the host never changes the pointer in the same cycle as a data access. The single `sel_data` select makes that second condition hold by construction. The stimulus drives every input on the falling edge and holds each strobe for exactly one rising edge. Apart from the deliberate dual-strobe case, it never raises read and write together. This keeps every auto-advance a single, countable step.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 3;
    localparam int RA_W      = 10;
    localparam int NUM_BANKS = 2;
    localparam int LAST_IDX  = 6;

    typedef enum logic [IDX_W-1:0] {
        SLOT_CMD_BASE = 3'd0,
        SLOT_GEN_CFG  = 3'd1,
        SLOT_RA_LO    = 3'd2,
        SLOT_RA_CFG   = 3'd3,
        SLOT_CTL_BASE = 3'd4,
        SLOT_DATA_TIM = 3'd5,
        SLOT_CTRL_TIM = 3'd6,
        SLOT_EMPTY    = 3'd7
    } slot_e;

    // Bit order matters: host software writes these positions.
    typedef struct packed {
        logic             auto_inc;
        logic             post_wait;
        logic             burst_dis;
        logic             devsel_med;
        logic             bank;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    typedef struct packed {
        logic dma_en;
        logic drv_rst;
        logic iordy_en;
        logic byte_port;
        logic irq_low;
        logic pwr_save;
        logic bus_master;
        logic io_en;
    } gen_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] cmd_base;
        logic [DATA_W-1:0] ctl_base;
        gen_cfg_t          gen;
        logic [RA_W-1:0]   ra_count;
        logic              ra_en;
        logic [BYTE_W-1:0] data_tim;
        logic [BYTE_W-1:0] ctrl_tim;
    } bank_regs_t;

    localparam logic [BYTE_W-1:0] PTR_RESET   = 8'h50;
    localparam logic [BYTE_W-1:0] PTR_RD_MASK = 8'hDF;
    localparam logic [BYTE_W-1:0] GEN_RESET   = 8'h01;
    localparam logic [BYTE_W-1:0] GEN_RD_MASK = 8'hFB;

    function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] cur);
        return (cur >= IDX_W'(LAST_IDX)) ? '0 : cur + 1'b1;
    endfunction

    function automatic logic [DATA_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
        return {{(DATA_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/ide_cfg_ptr.sv
module ide_cfg_ptr
    import ide_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_wr,
    input  logic [BYTE_W-1:0] ptr_wdata,
    input  logic              data_access,
    output ptr_t              ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= ptr_t'(PTR_RESET);
        end else if (ptr_wr) begin
            ptr_q <= ptr_t'(ptr_wdata);
        end else if (data_access && ptr_q.auto_inc) begin
            ptr_q.idx <= next_slot(ptr_q.idx);
        end
    end

endmodule

// File: rtl/ide_cfg_bank.sv
module ide_cfg_bank
    import ide_cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] CMD_RST  = 16'h01F0,
    parameter logic [DATA_W-1:0] CTL_RST  = 16'h03F6,
    parameter logic [BYTE_W-1:0] DTIM_RST = 8'hF5,
    parameter logic [BYTE_W-1:0] CTIM_RST = 8'hDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output bank_regs_t        regs_q,
    output logic              fifo_clr_q,
    output logic [DATA_W-1:0] rd_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.cmd_base <= CMD_RST;
            regs_q.ctl_base <= CTL_RST;
            regs_q.gen      <= gen_cfg_t'(GEN_RESET);
            regs_q.ra_count <= '0;
            regs_q.ra_en    <= 1'b0;
            regs_q.data_tim <= DTIM_RST;
            regs_q.ctrl_tim <= CTIM_RST;
            fifo_clr_q      <= 1'b0;
        end else begin
            fifo_clr_q <= 1'b0;
            if (wr) begin
                case (slot_e'(idx))
                    SLOT_CMD_BASE: regs_q.cmd_base <= wdata;
                    SLOT_GEN_CFG:  regs_q.gen      <= gen_cfg_t'(wdata[BYTE_W-1:0]);
                    SLOT_RA_LO:    regs_q.ra_count[BYTE_W-1:0] <= wdata[BYTE_W-1:0];
                    SLOT_RA_CFG: begin
                        regs_q.ra_count[RA_W-1:BYTE_W] <= wdata[RA_W-BYTE_W-1:0];
                        regs_q.ra_en <= wdata[7];
                        fifo_clr_q   <= wdata[6];
                    end
                    SLOT_CTL_BASE: regs_q.ctl_base <= wdata;
                    SLOT_DATA_TIM: regs_q.data_tim <= wdata[BYTE_W-1:0];
                    SLOT_CTRL_TIM: regs_q.ctrl_tim <= wdata[BYTE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (slot_e'(idx))
            SLOT_CMD_BASE: rd_val = regs_q.cmd_base;
            SLOT_GEN_CFG:  rd_val = widen_byte(regs_q.gen & GEN_RD_MASK);
            SLOT_CTL_BASE: rd_val = regs_q.ctl_base;
            SLOT_DATA_TIM: rd_val = widen_byte(regs_q.data_tim);
            SLOT_CTRL_TIM: rd_val = widen_byte(regs_q.ctrl_tim);
            default:       rd_val = '0;
        endcase
    end

endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux
    import ide_cfg_pkg::*;
(
    input  ptr_t                            ptr,
    input  logic                            sel_data,
    input  logic [NUM_BANKS*DATA_W-1:0]     bank_rd,
    output logic [DATA_W-1:0]               rdata
);

    always_comb begin
        if (sel_data) begin
            rdata = bank_rd[ptr.bank*DATA_W +: DATA_W];
        end else begin
            rdata = widen_byte(ptr & PTR_RD_MASK);
        end
    end

endmodule

// File: rtl/ide_cfg_port.sv
module ide_cfg_port
    import ide_cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] PRI_CMD_RST = 16'h01F0,
    parameter logic [DATA_W-1:0] SEC_CMD_RST = 16'h0170,
    parameter logic [DATA_W-1:0] PRI_CTL_RST = 16'h03F6,
    parameter logic [DATA_W-1:0] SEC_CTL_RST = 16'h0376,
    parameter logic [BYTE_W-1:0] DTIM_RST    = 8'hF5,
    parameter logic [BYTE_W-1:0] CTIM_RST    = 8'hDE
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sel_data,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [15:0]                 wdata,
    output logic [15:0]                 rdata,
    output logic                        post_wait_o,
    output logic                        burst_dis_o,
    output logic                        devsel_med_o,
    output logic [31:0]                 cmd_base_o,
    output logic [31:0]                 ctl_base_o,
    output logic [15:0]                 gen_cfg_o,
    output logic [1:0]                  ide_rst_o,
    output logic [19:0]                 ra_count_o,
    output logic [1:0]                  ra_en_o,
    output logic [1:0]                  fifo_clr_o,
    output logic [15:0]                 data_tim_o,
    output logic [15:0]                 ctrl_tim_o
);

    ptr_t                        ptr_q;
    logic                        ptr_wr;
    logic                        data_access;
    logic                        data_wr;
    logic [NUM_BANKS*DATA_W-1:0] bank_rd;

    assign ptr_wr      = wr_en && !sel_data;
    assign data_access = sel_data && (wr_en || rd_en);
    assign data_wr     = sel_data && wr_en;

    ide_cfg_ptr u_ptr (
        .clk         (clk),
        .rst         (rst),
        .ptr_wr      (ptr_wr),
        .ptr_wdata   (wdata[BYTE_W-1:0]),
        .data_access (data_access),
        .ptr_q       (ptr_q)
    );

    assign post_wait_o  = ptr_q.post_wait;
    assign burst_dis_o  = ptr_q.burst_dis;
    assign devsel_med_o = ptr_q.devsel_med;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_regs_t regs;
        logic       bank_wr;

        assign bank_wr = data_wr && (ptr_q.bank == 1'(b));

        ide_cfg_bank #(
            .CMD_RST  ((b == 0) ? PRI_CMD_RST : SEC_CMD_RST),
            .CTL_RST  ((b == 0) ? PRI_CTL_RST : SEC_CTL_RST),
            .DTIM_RST (DTIM_RST),
            .CTIM_RST (CTIM_RST)
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr         (bank_wr),
            .idx        (ptr_q.idx),
            .wdata      (wdata),
            .regs_q     (regs),
            .fifo_clr_q (fifo_clr_o[b]),
            .rd_val     (bank_rd[b*DATA_W +: DATA_W])
        );

        assign cmd_base_o[b*DATA_W +: DATA_W] = regs.cmd_base;
        assign ctl_base_o[b*DATA_W +: DATA_W] = regs.ctl_base;
        assign gen_cfg_o[b*BYTE_W +: BYTE_W]  = regs.gen;
        assign ide_rst_o[b]                   = regs.gen.drv_rst;
        assign ra_count_o[b*RA_W +: RA_W]     = regs.ra_count;
        assign ra_en_o[b]                     = regs.ra_en;
        assign data_tim_o[b*BYTE_W +: BYTE_W] = regs.data_tim;
        assign ctrl_tim_o[b*BYTE_W +: BYTE_W] = regs.ctrl_tim;
    end

    ide_cfg_rdmux u_rdmux (
        .ptr      (ptr_q),
        .sel_data (sel_data),
        .bank_rd  (bank_rd),
        .rdata    (rdata)
    );

endmodule

// File: rtl/ide_cfg_port_chk.sv
module ide_cfg_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        sel_data,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic [7:0]  ptr_q,
    input logic [1:0]  fifo_clr_o
);

    p_ptr_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ptr_q == 8'h50);

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_data && (wr_en || rd_en) && ptr_q[7] && ptr_q[2:0] < 3'd6)
        |=> ptr_q[2:0] == $past(ptr_q[2:0]) + 3'd1);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_data && !ptr_q[7]) |=> $stable(ptr_q));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (sel_data && (wr_en || rd_en) && ptr_q[7] && ptr_q[2:0] >= 3'd6)
        |=> ptr_q[2:0] == 3'd0);

    p_empty_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_data && ptr_q[2:0] == 3'd7) |-> rdata == 16'h0000);

    p_wo_slots_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_data && (ptr_q[2:0] == 3'd2 || ptr_q[2:0] == 3'd3)) |-> rdata == 16'h0000);

    p_ptr_read_r9: assert property (@(posedge clk) disable iff (rst)
        !sel_data |-> (rdata[15:8] == 8'h00 && !rdata[5]));

    for (genvar b = 0; b < 2; b++) begin : g_fifo
        p_fifo_cause_r7: assert property (@(posedge clk) disable iff (rst)
            fifo_clr_o[b] |-> $past(sel_data && wr_en && ptr_q[3] == 1'(b)
                                    && ptr_q[2:0] == 3'd3 && wdata[6]));
    end

endmodule

bind ide_cfg_port ide_cfg_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_data   (sel_data),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .ptr_q      (ptr_q),
    .fifo_clr_o (fifo_clr_o)
);

// File: tb/tb_ide_cfg_port.sv
module tb_ide_cfg_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_data = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        post_wait_o, burst_dis_o, devsel_med_o;
    logic [31:0] cmd_base_o, ctl_base_o;
    logic [15:0] gen_cfg_o, data_tim_o, ctrl_tim_o;
    logic [1:0]  ide_rst_o, ra_en_o, fifo_clr_o;
    logic [19:0] ra_count_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    ide_cfg_port dut (
        .clk(clk), .rst(rst), .sel_data(sel_data), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .post_wait_o(post_wait_o),
        .burst_dis_o(burst_dis_o), .devsel_med_o(devsel_med_o),
        .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o), .gen_cfg_o(gen_cfg_o),
        .ide_rst_o(ide_rst_o), .ra_count_o(ra_count_o), .ra_en_o(ra_en_o),
        .fifo_clr_o(fifo_clr_o), .data_tim_o(data_tim_o), .ctrl_tim_o(ctrl_tim_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ptr(input logic [7:0] v);
        @(negedge clk);
        sel_data = 1'b0; wr_en = 1'b1; wdata = {8'h00, v};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_data(input logic [15:0] v);
        @(negedge clk);
        sel_data = 1'b1; wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_loc(input logic sel, output logic [15:0] v);
        @(negedge clk);
        sel_data = sel; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_slot(input string req, input logic [7:0] p, input logic [15:0] exp);
        logic [15:0] v;
        wr_ptr(p);
        rd_loc(1'b1, v);
        check(req, {16'h0, v}, {16'h0, exp});
    endtask

    task automatic t_reset_r1;
        logic [15:0] v;
        rd_loc(1'b0, v);
        check("R1 pointer", {16'h0, v}, 32'h50);
        check("R1 flags", {29'h0, post_wait_o, burst_dis_o, devsel_med_o}, 32'h5);
        check("R1 cmd bases", cmd_base_o, 32'h0170_01F0);
        check("R1 ctl bases", ctl_base_o, 32'h0376_03F6);
        check("R1 gen", {16'h0, gen_cfg_o}, 32'h0101);
        check("R1 timings", {data_tim_o, ctrl_tim_o}, 32'hF5F5_DEDE);
        check("R1 read-ahead", {10'h0, ra_count_o, ra_en_o}, 32'h0);
        expect_slot("R1 b0 slot0", 8'h00, 16'h01F0);
        expect_slot("R1 b0 slot1", 8'h01, 16'h0001);
        expect_slot("R1 b0 slot5", 8'h05, 16'h00F5);
        expect_slot("R1 b1 slot0", 8'h08, 16'h0170);
        expect_slot("R1 b1 slot4", 8'h0C, 16'h0376);
        expect_slot("R1 b1 slot6", 8'h0E, 16'h00DE);
    endtask

    task automatic t_bank_sel_r2;
        wr_ptr(8'h00);
        wr_data(16'h1234);
        check("R2 cmd bases", cmd_base_o, 32'h0170_1234);
        expect_slot("R2 other bank", 8'h08, 16'h0170);
        expect_slot("R2 this bank", 8'h00, 16'h1234);
    endtask

    task automatic t_autoinc_r3_r4;
        logic [15:0] v;
        wr_ptr(8'h8C);
        wr_data(16'h0A76);
        wr_data(16'h0011);
        wr_data(16'h0022);
        wr_data(16'h0BBB);
        wr_data(16'h00C1);
        check("R3 ctl b1", {16'h0, ctl_base_o[31:16]}, 32'h0A76);
        check("R3 dtim b1", {24'h0, data_tim_o[15:8]}, 32'h11);
        check("R3 ctim b1", {24'h0, ctrl_tim_o[15:8]}, 32'h22);
        check("R4 wrap write cmd b1", {16'h0, cmd_base_o[31:16]}, 32'h0BBB);
        check("R3 gen b1", {24'h0, gen_cfg_o[15:8]}, 32'hC1);
        wr_ptr(8'h8D);
        rd_loc(1'b1, v); check("R3 read step 5", {16'h0, v}, 32'h0011);
        rd_loc(1'b1, v); check("R3 read step 6", {16'h0, v}, 32'h0022);
        rd_loc(1'b1, v); check("R4 read wrap 0", {16'h0, v}, 32'h0BBB);
        wr_ptr(8'h0D);
        rd_loc(1'b1, v); check("R3 no-step first", {16'h0, v}, 32'h0011);
        rd_loc(1'b1, v); check("R3 no-step second", {16'h0, v}, 32'h0011);
    endtask

    task automatic t_empty_r5;
        logic [15:0] v;
        wr_ptr(8'h07);
        wr_data(16'hFFFF);
        rd_loc(1'b1, v);
        check("R5 read slot7", {16'h0, v}, 32'h0);
        check("R5 cmd b0", {16'h0, cmd_base_o[15:0]}, 32'h1234);
        check("R5 ctl b0", {16'h0, ctl_base_o[15:0]}, 32'h03F6);
        check("R5 gen b0", {24'h0, gen_cfg_o[7:0]}, 32'h01);
        check("R5 tims b0", {16'h0, data_tim_o[7:0], ctrl_tim_o[7:0]}, 32'hF5DE);
        check("R5 ra b0", {21'h0, ra_count_o[9:0], ra_en_o[0]}, 32'h0);
        wr_ptr(8'h87);
        rd_loc(1'b1, v);
        rd_loc(1'b1, v);
        check("R4 wrap from 7", {16'h0, v}, 32'h1234);
    endtask

    task automatic t_wo_r6_r7;
        logic [15:0] v;
        wr_ptr(8'h02);
        wr_data(16'h00AB);
        wr_ptr(8'h03);
        wr_data(16'h0083);
        check("R7 no pulse w/o bit6", {30'h0, fifo_clr_o}, 32'h0);
        check("R6 ra count", {22'h0, ra_count_o[9:0]}, 32'h3AB);
        check("R6 ra en", {31'h0, ra_en_o[0]}, 32'h1);
        rd_loc(1'b1, v); check("R6 slot3 reads 0", {16'h0, v}, 32'h0);
        expect_slot("R6 slot2 reads 0", 8'h02, 16'h0000);
        wr_ptr(8'h03);
        wr_data(16'h0040);
        check("R7 pulse", {30'h0, fifo_clr_o}, 32'h1);
        @(negedge clk);
        check("R7 pulse ends", {30'h0, fifo_clr_o}, 32'h0);
        check("R6 ra after rewrite", {21'h0, ra_count_o[9:0], ra_en_o[0]}, {21'h0, 10'h0AB, 1'b0});
        rd_loc(1'b1, v); check("R7 not stored", {16'h0, v}, 32'h0);
    endtask

    task automatic t_bytes_r8_r10;
        wr_ptr(8'h05);
        wr_data(16'hBE5A);
        check("R8 dtim low byte", {24'h0, data_tim_o[7:0]}, 32'h5A);
        expect_slot("R8 dtim read", 8'h05, 16'h005A);
        wr_ptr(8'h01);
        wr_data(16'h00FF);
        check("R8 gen out", {24'h0, gen_cfg_o[7:0]}, 32'hFF);
        expect_slot("R8 gen read masks bit2", 8'h01, 16'h00FB);
        check("R10 drive reset set", {30'h0, ide_rst_o}, 32'h3);
        wr_data(16'h0001);
        check("R10 drive reset clear", {30'h0, ide_rst_o}, 32'h2);
    endtask

    task automatic t_ptr_flags_r9;
        logic [15:0] v;
        wr_ptr(8'h2F);
        rd_loc(1'b0, v);
        check("R9 pointer readback", {16'h0, v}, 32'h0F);
        check("R9 flags", {29'h0, post_wait_o, burst_dis_o, devsel_med_o}, 32'h2);
        wr_ptr(8'hD0);
        check("R9 flags again", {29'h0, post_wait_o, burst_dis_o, devsel_med_o}, 32'h5);
    endtask

    task automatic t_dual_r11;
        logic [15:0] v;
        wr_ptr(8'h85);
        @(negedge clk);
        sel_data = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wdata = 16'h0033;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11 write taken", {24'h0, data_tim_o[7:0]}, 32'h33);
        rd_loc(1'b1, v);
        check("R11 single step", {16'h0, v}, 32'h00DE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_bank_sel_r2();
        t_autoinc_r3_r4();
        t_empty_r5();
        t_wo_r6_r7();
        t_bytes_r8_r10();
        t_ptr_flags_r9();
        t_dual_r11();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule